// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block sits on the host side of an asynchronous read-only memory that supports fast page access. A client hands it one read at a time through a valid/ready handshake, giving a byte address and a flag that selects 16-bit word reads or 8-bit byte reads. The controller drives the memory's word address, byte-select line, width-select line, chip enable and output enable. It counts a set number of clock cycles, latches the data bus and returns the result with a one-cycle strobe.

The memory delivers a word from a new location only after a long access time. Once a page is open, a read that differs only in the low address bits arrives about twice as fast. A page is 16 bytes, which is eight words. The controller therefore holds chip enable low between reads and remembers which page and which width are open. A request that hits the open page gets the short wait. Any other request gets the full wait. If no request arrives for a programmable number of idle cycles, chip enable is released so that the memory drops into standby. The three access times are given in nanoseconds together with the clock period, and they are rounded up to whole cycles.

Top module: `rom_page_reader`

## Requirements
- R1: After reset, req_ready=1, rsp_valid=0, mem_ce_n=1, mem_oe_n=1, mem_byte_n=1 (word width) and mem_bsel_en=0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both high. req_ready is low from the edge that takes a request up to and including the edge that captures its data. A request held pending while the block is busy is taken on the first edge after the capture.
- R3: On the edge that takes a request, the controller drives mem_ce_n=0 and mem_oe_n=0. When no page is open, rsp_valid rises exactly MISS_W cycles after that edge, where MISS_W = max(ceil(ACC_NS/CLK_NS), ceil(OE_NS/CLK_NS)).
- R4: A request whose address bits above bit 3 match the open page, and whose width flag matches the open width, completes exactly HIT_W cycles after the edge that takes it, where HIT_W = max(ceil(PAGE_NS/CLK_NS), ceil(OE_NS/CLK_NS)).
- R5: A request to a different page (any of req_addr[ADDR_W-1:4] differs) takes the full MISS_W wait.
- R6: A change of width flag closes the page, so the next read takes MISS_W even when the address lies in the same page.
- R7: mem_addr carries req_addr[ADDR_W-1:1]. In byte mode (req_byte=1), mem_byte_n=0, mem_bsel_en=1 and mem_bsel=req_addr[0], and rsp_data = {8'h00, mem_dq[7:0]}. In word mode, mem_byte_n=1, mem_bsel_en=0, req_addr[0] has no effect and rsp_data = mem_dq.
- R8: After IDLE_TO consecutive idle cycles with no request taken, mem_ce_n returns to 1 and the next read takes MISS_W. A same-page read that arrives sooner still takes HIT_W.
- R9: rsp_valid is high for exactly one cycle per read. mem_oe_n is back at 1 in that cycle, and the captured data was sampled while mem_oe_n was 0.
- R10: mem_addr, mem_bsel and mem_byte_n stay unchanged while a read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the read |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | One-cycle strobe: rsp_data holds a result |
| rsp_data | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W-1 | Word address to the memory |
| mem_bsel | output | 1 | Byte-select address line (lowest byte address bit) |
| mem_bsel_en | output | 1 | Drive enable for mem_bsel; low in word mode, where the pin carries data |
| mem_byte_n | output | 1 | Width select: 1 = word, 0 = byte |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | input | DATA_W | Memory data bus |

## Verification
Every cycle, the assertions check the following:
- output enable is never low without chip enable;
- the memory lines hold still during an access;
- the response strobe lasts one cycle, and it follows a cycle with output enable low;
- the controller goes busy after taking a request;
- the wait counter counts down without a break;
- the idle timeout closes the page.

Only the bench scenarios can show whether a wait is long enough and which wait a given read receives. The bench uses a memory model that puts garbage on the bus until the full, page or output-enable time has passed since the relevant line changed. Against that model, it checks both the exact response cycle and the data for page hits, page misses, width switches, timeouts and a request held during a busy read.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rd_state_e;

  // Nanoseconds to whole clock cycles, rounded up, at least one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_rd_wait_timer.sv
module rom_rd_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    expire = busy_q && (cnt_q == '0);
    en     = load || busy_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = load_val - CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // R2: the controller never reloads a running count
  a_r2_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);

  // R3: once started, the count falls by one per cycle until it ends
  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/rom_rd_page_track.sv
module rom_rd_page_track #(
  parameter int TAG_W   = 15,
  parameter int IDLE_TO = 16,
  parameter int IDLE_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  logic             start_mode,
  input  logic             quiet,
  output logic             open,
  output logic             hit
);

  logic              open_q, open_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic              mode_q, mode_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              en;
  logic              limit;

  assign limit = (idle_q == IDLE_W'(IDLE_TO - 1));

  always_comb begin
    open_d = open_q;
    tag_d  = tag_q;
    mode_d = mode_q;
    idle_d = idle_q;
    en     = start || (quiet && open_q);
    hit    = open_q && (tag_q == start_tag) && (mode_q == start_mode);
    if (start) begin
      open_d = 1'b1;
      tag_d  = start_tag;
      mode_d = start_mode;
      idle_d = '0;
    end else if (quiet && open_q) begin
      if (limit) begin
        open_d = 1'b0;
        idle_d = '0;
      end else begin
        idle_d = idle_q + IDLE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      tag_q  <= '0;
      mode_q <= 1'b0;
      idle_q <= '0;
    end else if (en) begin
      open_q <= open_d;
      tag_q  <= tag_d;
      mode_q <= mode_d;
      idle_q <= idle_d;
    end
  end

  assign open = open_q;

  // R8: the idle limit closes the page on the next edge
  a_r8_timeout_close: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && quiet && !start && limit) |=> !open_q);

  // R4: a page can only be opened by a request
  a_r4_open_by_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(start));

endmodule

// File: rtl/rom_page_reader.sv
module rom_page_reader
  import rom_rd_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 16,
  parameter int PAGE_LG = 4,
  parameter int CLK_NS  = 20,
  parameter int ACC_NS  = 90,
  parameter int PAGE_NS = 50,
  parameter int OE_NS   = 45,
  parameter int IDLE_TO = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_byte,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-2:0] mem_addr,
  output logic              mem_bsel,
  output logic              mem_bsel_en,
  output logic              mem_byte_n,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_dq
);

  localparam int unsigned ACC_C  = ns_to_cyc(ACC_NS, CLK_NS);
  localparam int unsigned PAGE_C = ns_to_cyc(PAGE_NS, CLK_NS);
  localparam int unsigned OE_C   = ns_to_cyc(OE_NS, CLK_NS);
  localparam int unsigned MISS_W = max_u(ACC_C, OE_C);
  localparam int unsigned HIT_W  = max_u(PAGE_C, OE_C);
  localparam int CNT_W  = $clog2(MISS_W + 1);
  localparam int TAG_W  = ADDR_W - PAGE_LG;
  localparam int IDLE_W = $clog2(IDLE_TO + 1);
  localparam int BYTE_W = DATA_W / 2;

  rd_state_e         state_q, state_d;
  logic              accept, expire, page_hit, page_open;
  logic [CNT_W-1:0]  wait_val;
  logic [ADDR_W-2:0] addr_q;
  logic              bsel_q, byte_q, oe_n_q, oe_n_d, rsp_v_q;
  logic [DATA_W-1:0] data_q, data_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign wait_val  = page_hit ? CNT_W'(HIT_W) : CNT_W'(MISS_W);

  rom_rd_page_track #(
    .TAG_W  (TAG_W),
    .IDLE_TO(IDLE_TO),
    .IDLE_W (IDLE_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_tag (req_addr[ADDR_W-1:PAGE_LG]),
    .start_mode(req_byte),
    .quiet     (req_ready),
    .open      (page_open),
    .hit       (page_hit)
  );

  rom_rd_wait_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val(wait_val),
    .expire  (expire)
  );

  // next state
  always_comb begin
    state_d = state_q;
    oe_n_d  = oe_n_q;
    if (accept) begin
      state_d = ST_WAIT;
      oe_n_d  = 1'b0;
    end else if (expire) begin
      state_d = ST_IDLE;
      oe_n_d  = 1'b1;
    end
  end

  always_comb begin
    if (byte_q) data_d = {{(DATA_W-BYTE_W){1'b0}}, mem_dq[BYTE_W-1:0]};
    else        data_d = mem_dq;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      oe_n_q  <= 1'b1;
      rsp_v_q <= 1'b0;
    end else begin
      if (accept || expire) begin
        state_q <= state_d;
        oe_n_q  <= oe_n_d;
      end
      rsp_v_q <= expire;
    end
  end

  // address registers, loaded when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bsel_q <= 1'b0;
      byte_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr[ADDR_W-1:1];
      bsel_q <= req_byte & req_addr[0];
      byte_q <= req_byte;
    end
  end

  // data register, loaded at the end of the wait
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (expire) data_q <= data_d;
  end

  assign rsp_valid   = rsp_v_q;
  assign rsp_data    = data_q;
  assign mem_addr    = addr_q;
  assign mem_bsel    = bsel_q;
  assign mem_bsel_en = byte_q;
  assign mem_byte_n  = ~byte_q;
  assign mem_ce_n    = ~page_open;
  assign mem_oe_n    = oe_n_q;

  // R2: busy right after a request is taken
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R3: output enable only together with chip enable
  a_r3_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);

  // R10: memory lines hold still during an access
  a_r10_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> ($stable(mem_addr) && $stable(mem_bsel) && $stable(mem_byte_n)));

  // R9: single-cycle strobe
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: output enable released when the result is presented
  a_r9_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_oe_n);

  // R9: data was sampled under output enable
  a_r9_sampled_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));

endmodule

// File: tb/rom_page_reader_bench.sv
`timescale 1ns/1ps
module rom_page_reader_bench;

  localparam int CLK_NS  = 20;
  localparam int ACC_NS  = 90;
  localparam int PAGE_NS = 50;
  localparam int OE_NS   = 45;
  localparam int IDLE_TO = 16;
  localparam int ACC_C   = (ACC_NS + CLK_NS - 1) / CLK_NS;   // 5
  localparam int PAGE_C  = (PAGE_NS + CLK_NS - 1) / CLK_NS;  // 3
  localparam int OE_C    = (OE_NS + CLK_NS - 1) / CLK_NS;    // 3
  localparam int MISS    = (ACC_C > OE_C) ? ACC_C : OE_C;
  localparam int HIT     = (PAGE_C > OE_C) ? PAGE_C : OE_C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [18:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [17:0] mem_addr;
  logic        mem_bsel, mem_bsel_en, mem_byte_n, mem_ce_n, mem_oe_n;
  logic [15:0] mem_dq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rom_page_reader #(
    .ADDR_W(19), .DATA_W(16), .PAGE_LG(4), .CLK_NS(CLK_NS), .ACC_NS(ACC_NS),
    .PAGE_NS(PAGE_NS), .OE_NS(OE_NS), .IDLE_TO(IDLE_TO)
  ) u_rom_page_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_bsel(mem_bsel), .mem_bsel_en(mem_bsel_en),
    .mem_byte_n(mem_byte_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
  );

  // ---------------- memory model with access-time ageing ----------------
  function automatic logic [15:0] romw(input logic [17:0] a);
    logic [15:0] m;
    m = a[15:0] * 16'h9E37;
    return m ^ {14'h0, a[17:16]} ^ 16'h1234;
  endfunction

  function automatic logic [15:0] exp_data(input logic [18:0] a, input logic bm);
    logic [15:0] w;
    w = romw(a[18:1]);
    if (!bm) return w;
    return {8'h00, (a[0] ? w[15:8] : w[7:0])};
  endfunction

  logic [17:0] p_addr = '0;
  logic        p_bsel = 1'b0, p_byten = 1'b1, p_ce = 1'b1, p_oe = 1'b1;
  int age_ce = 0, age_oe = 0, age_hi = 0, age_lo = 0;
  logic [15:0] dq_drv = 16'hBAD0;
  assign mem_dq = dq_drv;

  always @(negedge clk) begin
    logic ok;
    logic [15:0] w;
    if (mem_ce_n || p_ce) age_ce = 0; else if (age_ce < 1000) age_ce++;
    if (mem_oe_n || p_oe) age_oe = 0; else if (age_oe < 1000) age_oe++;
    if (mem_addr[17:3] !== p_addr[17:3] || mem_byte_n !== p_byten) age_hi = 0;
    else if (age_hi < 1000) age_hi++;
    if (mem_addr !== p_addr || mem_bsel !== p_bsel || mem_byte_n !== p_byten) age_lo = 0;
    else if (age_lo < 1000) age_lo++;
    p_addr = mem_addr; p_bsel = mem_bsel; p_byten = mem_byte_n;
    p_ce = mem_ce_n; p_oe = mem_oe_n;
    ok = !mem_ce_n && !mem_oe_n && (age_ce + 1 >= ACC_C) && (age_hi + 1 >= ACC_C)
         && (age_lo + 1 >= PAGE_C) && (age_oe + 1 >= OE_C);
    w = romw(mem_addr);
    if (!ok)             dq_drv = 16'hBAD0;
    else if (mem_byte_n) dq_drv = w;
    else                 dq_drv = {8'hEE, (mem_bsel ? w[15:8] : w[7:0])};
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [15:0] data;
    int          due;
    string       rq;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit cond, input string rq, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  logic prev_rsp = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        check(!prev_rsp, "R9", "strobe longer than one cycle", prev_rsp, 0);
        check(mem_oe_n == 1'b1, "R9", "oe_n at result", mem_oe_n, 1);
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected result", rsp_data, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_data == e.data, e.rq, "data", rsp_data, e.data);
          check(cyc == e.due, e.rq, "result cycle", cyc, e.due);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  // issue one read; w = expected wait in cycles
  task automatic issue(input logic [18:0] a, input logic bm, input int w, input string rq);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_byte = bm;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    sb.push_back('{exp_data(a, bm), cyc + w, rq});
    check(req_ready == 1'b0, "R2", "ready after accept", req_ready, 0);
    check(mem_ce_n == 1'b0 && mem_oe_n == 1'b0, "R3", "ce_n/oe_n low", {mem_ce_n, mem_oe_n}, 0);
    check(mem_addr == a[18:1], "R7", "mem_addr", mem_addr, a[18:1]);
    check(mem_byte_n == !bm && mem_bsel_en == bm, "R7", "width lines",
          {mem_byte_n, mem_bsel_en}, {!bm, bm});
    check(mem_bsel == (bm & a[0]), "R7", "byte select", mem_bsel, bm & a[0]);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic read(input logic [18:0] a, input logic bm, input int w, input string rq);
    issue(a, bm, w, rq);
    drain();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (1000 * 200) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready && !rsp_valid && mem_ce_n && mem_oe_n && mem_byte_n && !mem_bsel_en,
          "R1", "reset outputs", {req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_byte_n, mem_bsel_en},
          6'b101110);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_ce_n, "R1", "after release", {req_ready, mem_ce_n}, 2'b11);

    read(19'h00120, 1'b0, MISS, "R3");   // first access, full wait
    read(19'h0012E, 1'b0, HIT,  "R4");   // same page, short wait
    read(19'h0012F, 1'b0, HIT,  "R7");   // word mode ignores bit 0
    read(19'h00130, 1'b0, MISS, "R5");   // next page
    read(19'h00131, 1'b1, MISS, "R6");   // width change, upper byte
    read(19'h00134, 1'b1, HIT,  "R7");   // byte hit, lower byte
    read(19'h00132, 1'b0, MISS, "R6");   // back to word width
    read(19'h7FFF0, 1'b0, MISS, "R5");   // top page
    read(19'h7FFFE, 1'b0, HIT,  "R4");

    // R8: short idle keeps the page open
    repeat (8) @(negedge clk);
    check(mem_ce_n == 1'b0, "R8", "ce held before timeout", mem_ce_n, 0);
    read(19'h7FFF8, 1'b0, HIT, "R8");
    // R8: long idle closes it
    repeat (IDLE_TO + 4) @(negedge clk);
    check(mem_ce_n == 1'b1, "R8", "ce released after timeout", mem_ce_n, 1);
    read(19'h7FFFA, 1'b0, MISS, "R8");

    // R2/R10: request held pending while a read is running
    issue(19'h04400, 1'b0, MISS, "R2");
    req_valid = 1'b1; req_addr = 19'h04406; req_byte = 1'b0;
    while (!req_ready) begin
      check(mem_addr == 18'h02200, "R10", "address held", mem_addr, 18'h02200);
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    sb.push_back('{exp_data(19'h04406, 1'b0), cyc + HIT, "R2"});
    drain();

    // byte reads across a full page, all hits after the first
    read(19'h01230, 1'b1, MISS, "R7");
    for (int i = 1; i < 16; i++) read(19'h01230 + 19'(i), 1'b1, HIT, "R7");

    repeat (3) @(negedge clk);
    summary();
  end

endmodule